// File: doc/BRIEF.md
# PWM Output Steering Controller

This block takes one PWM waveform and decides, pin by pin, which of four outputs (A, B, C, D) carry it. Each output either follows the PWM with a polarity inversion of its own, or passes through the general-purpose port data bit for that pin. An 8-bit control register selects the routing. Each pin can be enabled on its own. As an alternative, pin A can be paired with one partner pin that drives the inverse waveform.

Register writes can reach the pins on the next clock. They can also be held in a shadow copy until the next PWM period starts, so that the routing never changes in the middle of a period. Routing applies only while the mode-valid input reports single-output PWM mode. Otherwise every pin shows its port data.

Top module: `pwm_steer`

## Requirements
- R1: After reset the register reads 0x01, so only pin A carries the PWM and every other field is 0.
- R2: A write with wr_en_i stores wr_data_i in the shadow register, and bit 5 always reads 0. rd_data_o returns the shadow value even while the active routing still holds an older setting.
- R3: When the complementary select (bits 7:6) is 00, pin k (bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D) drives the polarity-adjusted PWM if its enable bit is 1, and drives port_i[k] if it is 0.
- R4: pol_i[1] = 1 inverts the PWM on pins A and C. pol_i[0] = 1 inverts it on pins B and D.
- R5: Complementary select 01 pairs A with B, 10 pairs A with C, and 11 pairs A with D.
- R6: In a complementary pair, pin A drives the PWM and the partner drives the inverted PWM, each with its own polarity applied. The two remaining pins drive port data, and bits 3:0 have no effect.
- R7: While mode_valid_i is 0, every pin drives its port_i bit.
- R8: A write with bit 4 = 0 takes effect at the pins from the cycle after the write edge.
- R9: A write with bit 4 = 1 leaves the pins unchanged until a clock edge at which period_start_i is 1. At that edge the active routing loads the shadow value.
- R10: When an immediate write (bit 4 = 0) and period_start_i arrive in the same cycle, the written value becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register readback (shadow value) |
| pwm_i | input | 1 | Raw PWM waveform |
| period_start_i | input | 1 | Strobe for the start of a PWM period |
| mode_valid_i | input | 1 | High when the PWM is in single-output mode |
| pol_i | input | 2 | Polarity: bit 1 for A/C, bit 0 for B/D, 1 = active-low |
| port_i | input | 4 | Port data for pins D..A |
| pin_o | output | 4 | Pin values D..A |

## Verification
The bench builds the block with its defaults: four pins, a 2-bit pair select and an 8-bit control word. With these values every pair code and every individual-enable pattern can be reached in a few thousand cycles. Random writes, strobes and polarity settings are mixed with directed cases that hold a deferred write across idle cycles and that make an immediate write collide with a period strobe. The bench keeps its own shadow and active routing model. Pin and readback values are compared against this model in every cycle.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int CTRL_W     = 8;
  localparam int SYNC_BIT   = 4;
  localparam int SEL_LSB    = 6;
  localparam int SEL_W      = CTRL_W - SEL_LSB;
  localparam int NUM_PINS   = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 8'h01;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 8'hDF;

  typedef struct packed {
    logic [SEL_W-1:0]    sel;
    logic [NUM_PINS-1:0] en;
  } route_t;
endpackage

// File: rtl/steer_ctrl_reg.sv
module steer_ctrl_reg
  import pwm_steer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              period_start_i,
  output logic [CTRL_W-1:0] shadow_o,
  output route_t            active_o
);
  localparam route_t ROUTE_RST = '{sel: CTRL_RST[CTRL_W-1:SEL_LSB], en: CTRL_RST[NUM_PINS-1:0]};

  logic [CTRL_W-1:0] shadow_q;
  route_t            active_q;
  logic              wr_now;
  route_t            wr_route, sh_route;

  assign wr_now   = wr_en_i && !wr_data_i[SYNC_BIT];
  assign wr_route = '{sel: wr_data_i[CTRL_W-1:SEL_LSB], en: wr_data_i[NUM_PINS-1:0]};
  assign sh_route = '{sel: shadow_q[CTRL_W-1:SEL_LSB], en: shadow_q[NUM_PINS-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= CTRL_RST;
      active_q <= ROUTE_RST;
    end else begin
      if (wr_en_i) shadow_q <= wr_data_i & CTRL_MASK;
      // immediate write wins over a period reload
      if (wr_now)              active_q <= wr_route;
      else if (period_start_i) active_q <= sh_route;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

  // R8
  imm_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_data_i[SYNC_BIT] |=> active_q == $past(wr_route));
  // R9
  period_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i && !(wr_en_i && !wr_data_i[SYNC_BIT]) |=> active_q == $past(sh_route));
  // R9
  hold_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_start_i && !(wr_en_i && !wr_data_i[SYNC_BIT]) |=> $stable(active_q));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> shadow_q[5] == 1'b0 && shadow_q[SYNC_BIT] == $past(wr_data_i[SYNC_BIT]));
endmodule

// File: rtl/steer_pin_mux.sv
module steer_pin_mux
  import pwm_steer_pkg::*;
(
  input  route_t              route_i,
  input  logic                mode_valid_i,
  input  logic                pwm_i,
  input  logic [1:0]          pol_i,
  input  logic [NUM_PINS-1:0] port_i,
  output logic [NUM_PINS-1:0] pin_o
);
  logic pair_mode;
  assign pair_mode = route_i.sel != '0;

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    logic inv_k, partner_k, drive_k, wave_k;
    // even pins (A, C) use pol bit 1, odd pins (B, D) use pol bit 0
    assign inv_k     = (k % 2 == 0) ? pol_i[1] : pol_i[0];
    assign partner_k = (k != 0) && (route_i.sel == SEL_W'(k));
    assign drive_k   = mode_valid_i &&
                       (pair_mode ? ((k == 0) || partner_k) : route_i.en[k]);
    assign wave_k    = (partner_k ? ~pwm_i : pwm_i) ^ inv_k;
    assign pin_o[k]  = drive_k ? wave_k : port_i[k];
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  input  logic              pwm_i,
  input  logic              period_start_i,
  input  logic              mode_valid_i,
  input  logic [1:0]        pol_i,
  input  logic [3:0]        port_i,
  output logic [3:0]        pin_o
);
  route_t active;

  steer_ctrl_reg u_reg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .period_start_i (period_start_i),
    .shadow_o       (rd_data_o),
    .active_o       (active)
  );

  steer_pin_mux u_mux (
    .route_i      (active),
    .mode_valid_i (mode_valid_i),
    .pwm_i        (pwm_i),
    .pol_i        (pol_i),
    .port_i       (port_i),
    .pin_o        (pin_o)
  );

  // R7
  idle_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_valid_i |-> pin_o == port_i);
  // R6
  pair_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_valid_i && active.sel != '0 |->
      ((pin_o[0] ^ pol_i[1]) != (pin_o[active.sel] ^ (active.sel[0] ? pol_i[0] : pol_i[1]))));
  // R6
  pair_spare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_valid_i && active.sel == 2'd1 |-> pin_o[3:2] == port_i[3:2]);
endmodule

// File: tb/pwm_steer_tb_top.sv
`timescale 1ns/1ps
module pwm_steer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       pwm = 1'b0, ps = 1'b0, mv = 1'b1;
  logic [1:0] pol = '0;
  logic [3:0] port = '0;
  logic [3:0] pin;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_shadow, m_active;

  always #4 clk = ~clk;

  pwm_steer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pwm_i(pwm), .period_start_i(ps),
    .mode_valid_i(mv), .pol_i(pol), .port_i(port), .pin_o(pin)
  );

  function automatic logic [3:0] exp_pins(logic [7:0] act);
    logic [3:0] r;
    logic [1:0] sel = act[7:6];
    for (int k = 0; k < 4; k++) begin
      logic inv = (k % 2 == 0) ? pol[1] : pol[0];
      logic drv;
      logic w = pwm;
      if (sel != 0) begin
        drv = (k == 0) || (k == int'(sel));
        if (k != 0 && k == int'(sel)) w = ~pwm;
      end else drv = act[k];
      r[k] = (mv && drv) ? (w ^ inv) : port[k];
    end
    return r;
  endfunction

  function automatic string pin_tag();
    if (!mv) return "R7";
    if (m_active[7:6] != 0) return "R6";
    return "R3/R4";
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " pins ", pin_tag()}, {4'h0, pin}, {4'h0, exp_pins(m_active)});
    chk({tag, " readback R2"}, rd_data, m_shadow);
  endtask

  // inputs set after negedge; model updated at posedge; checked at next negedge
  task automatic cycle(string tag);
    @(posedge clk);
    if (wr_en && !wr_data[4]) m_active = wr_data & 8'hDF;
    else if (ps)              m_active = m_shadow;
    if (wr_en) m_shadow = wr_data & 8'hDF;
    @(negedge clk);
    wr_en = 0; ps = 0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    m_shadow = 8'h01; m_active = 8'h01;
    port = 4'b1010; pwm = 1;
    #20; @(negedge clk); rst_n = 1;
    check_all("R1 reset");
    chk("R1 reset value", rd_data, 8'h01);

    // R8 immediate enable of B and D, bit 5 set in write
    wr_en = 1; wr_data = 8'h2A; cycle("R8");
    chk("R2 bit5 reads 0", rd_data, 8'h0A);
    chk("R8 B,D driven", {4'h0, pin}, {4'h0, exp_pins(8'h0A)});

    // R9 deferred write to pair A/C, held over idle cycles
    wr_en = 1; wr_data = 8'h91; cycle("R9 write");
    chk("R2 shadow shown", rd_data, 8'h91);
    chk("R9 still old", {4'h0, pin}, {4'h0, exp_pins(8'h0A)});
    for (int i = 0; i < 3; i++) cycle("R9 hold");
    ps = 1; cycle("R9 strobe");
    chk("R5 pair A/C", {4'h0, pin}, {4'h0, exp_pins(8'h91)});

    // R5 every pair code, both pwm levels
    for (int s = 1; s < 4; s++) begin
      wr_en = 1; wr_data = {s[1:0], 6'h0F}; cycle("R5 pair");
      pwm = ~pwm; #1; check_all("R5 pair pwm flip");
    end

    // R10 collision: immediate write and strobe in same cycle
    wr_en = 1; wr_data = 8'h14; cycle("R10 pre");
    wr_en = 1; wr_data = 8'h03; ps = 1; cycle("R10");
    chk("R10 write wins", {4'h0, pin}, {4'h0, exp_pins(8'h03)});

    // R7 mode invalid
    mv = 0; port = 4'b0101; #1; check_all("R7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      wr_en   = ($urandom % 4) == 0;
      wr_data = 8'($urandom);
      ps      = ($urandom % 8) == 0;
      mv      = ($urandom % 8) != 0;
      pol     = 2'($urandom);
      port    = 4'($urandom);
      pwm     = 1'($urandom);
      cycle("rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule